// File: doc/BRIEF.md
# Serial Mode-Control Command Port

This block is the configuration port of an audio oversampling filter when the filter runs in program mode. An external controller uses four plain pins to write settings. A three-bit command code selects the operation, a serial data pin carries the bits, and an enable strobe clocks each bit in on its rising edge. The strobe is asynchronous to the system clock, so it passes through a synchronizer and an edge detector. Each detected rising edge takes one bit.

The block holds a 24-bit mode register and two 9-bit attenuation registers, one per channel. A register is written only when a word has been received in full. A partial word is dropped if the command code changes before the word is complete.

The mode register is decoded into named outputs: oversampling rate, output word size, input latch polarity, input justification, word-clock polarity, output coding, input word-clock start edge, the two deglitch edge slots and the dither mode. When program mode is off, the block presents fixed stand-alone settings on these outputs and ignores the strobe. A flag marks illegal mode combinations. The datapath that consumes the settings lies outside this block. All pins here are level-type control pins, so there is no valid/ready handshake and no back-pressure.

Top module: `mode_ctl_port`

## Requirements
- R1: After reset the mode register holds the stand-alone word 0x06FBC3. The decoded outputs read 8 Fs, 24-bit, deglitch fall slot 15, deglitch rise slot 31, with all polarity, coding and dither fields 0. Both attenuators read 0 and `cfg_err` is 0.
- R2: The strobe is synchronized through two flops. Each rising edge takes exactly one bit, however long the strobe stays high.
- R3: Command 000 shifts the mode word, 24 bits. Received bit k lands at word bit k. The positions are: 0 and 1 are the rate code bits 0 and 1; 2 is input latch on falling edge; 3 is right-justified input; 4 is word-clock boundary on rising edge; 5 is offset-binary output; 10:6 is the deglitch fall slot; 15:11 is the deglitch rise slot; 16 is input start on falling edge; 18:17 is the word size; 21:19 is the dither mode; 22 and 23 are reserved. Multi-bit fields therefore arrive LSB first. The register and its outputs change only after the 24th bit.
- R4: Commands 001, 010 and 011 shift a 9-bit attenuation word MSB first. After the 9th bit it is written to the left register, the right register, or both, in that order of codes. The register that is not addressed is unchanged.
- R5: A single edge under command 100 clears both attenuators.
- R6: Edges under commands 101, 110 and 111 change no register.
- R7: A change of command code between edges discards the partial word. The new command starts counting from its first bit.
- R8: While `prog_en` is low, the outputs show the stand-alone values from R1, the attenuators read 0, `cfg_err` is 0, and strobe edges change no register.
- R9: In program mode `cfg_err` is 1 if either reserved bit is 1, if the rate code is 00, or if the rate is 2 Fs with a word size other than 24 bits.
- R10: `os_code` is {bit1, bit0}: 01 means 2 Fs, 10 means 4 Fs, 11 means 8 Fs. `word_size` is {bit18, bit17}: 00 means 16, 01 means 18, 10 means 20, 11 means 24 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en | input | 1 | 1 selects program mode, 0 selects stand-alone mode |
| cmd_sel | input | 3 | Command code, held stable around each strobe edge |
| ser_bit | input | 1 | Serial data bit, held stable around each strobe edge |
| strobe | input | 1 | Asynchronous enable strobe; a rising edge takes one bit |
| os_code | output | 2 | Oversampling rate code (R10) |
| word_size | output | 2 | Output word size code (R10) |
| in_fall_latch | output | 1 | Input data latched on the falling bit-clock edge |
| in_rjust | output | 1 | Input data right-justified, 16 bits |
| wck_rise | output | 1 | Output word boundary on the rising word-clock edge |
| out_offset_bin | output | 1 | Output coded as complementary offset binary |
| lr_fall_start | output | 1 | Input word-clock falling edge starts a frame |
| dg_fall_slot | output | 5 | Deglitch falling-edge interval |
| dg_rise_slot | output | 5 | Deglitch rising-edge interval |
| dither_mode | output | 3 | Dither mode 0 to 7 |
| att_left | output | 9 | Left-channel attenuation step count |
| att_right | output | 9 | Right-channel attenuation step count |
| cfg_err | output | 1 | Illegal mode combination flag (R9) |

## Verification
Two things can happen on the same strobe edge: a new command code arrives while a word of another command is half shifted, so the partial word is dropped and the new command acts in that one edge. The bench provokes this in three ways. It sends four attenuation bits and then a zero command, then a full 9-bit load. It sends part of a mode word and then switches to an attenuation load. It also switches program mode off in the middle of traffic. The result is judged at the ports. The later load must appear exactly, with no stale bits shifted into it. The mode outputs must keep their earlier values. The zero command must clear both channels.

// File: rtl/mcp_pkg.sv
package mcp_pkg;

  localparam int MODE_W = 24;
  localparam int CMD_W  = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_MODE     = 3'b000,
    CMD_ATT_L    = 3'b001,
    CMD_ATT_R    = 3'b010,
    CMD_ATT_BOTH = 3'b011,
    CMD_ATT_ZERO = 3'b100
  } cmd_e;

  // Packed so that field bit positions equal the serial arrival index.
  typedef struct packed {
    logic       rsv_b;     // 23
    logic       rsv_a;     // 22
    logic [2:0] dither;    // 21:19
    logic [1:0] wsz;       // 18:17
    logic       lr_fall;   // 16
    logic [4:0] dg_rise;   // 15:11
    logic [4:0] dg_fall;   // 10:6
    logic       offs_bin;  // 5
    logic       wck_rise;  // 4
    logic       rjust;     // 3
    logic       fall_lat;  // 2
    logic [1:0] os;        // 1:0
  } mode_cfg_t;

  localparam logic [1:0] OS_2X   = 2'b01;
  localparam logic [1:0] OS_NONE = 2'b00;
  localparam logic [1:0] WSZ_24  = 2'b11;

  // 8 Fs, 24-bit, fall slot 15, rise slot 31, all else 0.
  localparam logic [MODE_W-1:0] MODE_STANDALONE = 24'h06FBC3;

endpackage

// File: rtl/mcp_strobe_sync.sv
module mcp_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic rise_o
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], strobe_i};
  end

  assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/mcp_shifter.sv
module mcp_shifter
  import mcp_pkg::*;
#(
  parameter int ATT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_i,
  input  logic              rise_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              bit_i,
  output logic              mode_we_o,
  output logic [MODE_W-1:0] mode_word_o,
  output logic              att_we_l_o,
  output logic              att_we_r_o,
  output logic              att_zero_o,
  output logic [ATT_W-1:0]  att_word_o
);
  localparam int LONGEST = (MODE_W > ATT_W) ? MODE_W : ATT_W;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] MODE_LAST = CNT_W'(MODE_W - 1);
  localparam logic [CNT_W-1:0] ATT_LAST  = CNT_W'(ATT_W - 1);

  logic [CNT_W-1:0]  cnt, cnt_base;
  logic [CMD_W-1:0]  last_cmd;
  logic              active, fresh;
  logic [MODE_W-1:0] msh, m_base, m_next;
  logic [ATT_W-1:0]  ash, a_base, a_next;
  cmd_e              cmd;

  assign cmd = cmd_e'(cmd_i);

  always_comb begin
    fresh    = !active || (cmd_i != last_cmd);
    cnt_base = fresh ? '0 : cnt;
    m_base   = fresh ? '0 : msh;
    a_base   = fresh ? '0 : ash;
    m_next   = {bit_i, m_base[MODE_W-1:1]};      // LSB arrives first
    a_next   = {a_base[ATT_W-2:0], bit_i};       // MSB arrives first
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      last_cmd    <= '0;
      active      <= 1'b0;
      msh         <= '0;
      ash         <= '0;
      mode_we_o   <= 1'b0;
      mode_word_o <= '0;
      att_we_l_o  <= 1'b0;
      att_we_r_o  <= 1'b0;
      att_zero_o  <= 1'b0;
      att_word_o  <= '0;
    end else begin
      mode_we_o  <= 1'b0;
      att_we_l_o <= 1'b0;
      att_we_r_o <= 1'b0;
      att_zero_o <= 1'b0;
      if (!prog_i) begin
        cnt    <= '0;
        active <= 1'b0;
      end else if (rise_i) begin
        last_cmd <= cmd_i;
        case (cmd)
          CMD_MODE: begin
            if (cnt_base == MODE_LAST) begin
              mode_we_o   <= 1'b1;
              mode_word_o <= m_next;
              cnt         <= '0;
              active      <= 1'b0;
            end else begin
              msh    <= m_next;
              cnt    <= cnt_base + 1'b1;
              active <= 1'b1;
            end
          end
          CMD_ATT_L, CMD_ATT_R, CMD_ATT_BOTH: begin
            if (cnt_base == ATT_LAST) begin
              att_we_l_o <= (cmd != CMD_ATT_R);
              att_we_r_o <= (cmd != CMD_ATT_L);
              att_word_o <= a_next;
              cnt        <= '0;
              active     <= 1'b0;
            end else begin
              ash    <= a_next;
              cnt    <= cnt_base + 1'b1;
              active <= 1'b1;
            end
          end
          CMD_ATT_ZERO: begin
            att_zero_o <= 1'b1;
            cnt        <= '0;
            active     <= 1'b0;
          end
          default: begin
            cnt    <= '0;
            active <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/mcp_cfg_regs.sv
module mcp_cfg_regs
  import mcp_pkg::*;
#(
  parameter int ATT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_word_i,
  input  logic              att_we_l_i,
  input  logic              att_we_r_i,
  input  logic              att_zero_i,
  input  logic [ATT_W-1:0]  att_word_i,
  output logic [MODE_W-1:0] mode_q_o,
  output logic [ATT_W-1:0]  att_l_o,
  output logic [ATT_W-1:0]  att_r_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q_o <= MODE_STANDALONE;
    else if (mode_we_i) mode_q_o <= mode_word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      att_l_o <= '0;
      att_r_o <= '0;
    end else if (att_zero_i) begin
      att_l_o <= '0;
      att_r_o <= '0;
    end else begin
      if (att_we_l_i) att_l_o <= att_word_i;
      if (att_we_r_i) att_r_o <= att_word_i;
    end
  end
endmodule

// File: rtl/mcp_cfg_view.sv
module mcp_cfg_view
  import mcp_pkg::*;
#(
  parameter int ATT_W = 9
) (
  input  logic              prog_i,
  input  logic [MODE_W-1:0] mode_q_i,
  input  logic [ATT_W-1:0]  att_l_i,
  input  logic [ATT_W-1:0]  att_r_i,
  output mode_cfg_t         cfg_o,
  output logic [ATT_W-1:0]  att_l_o,
  output logic [ATT_W-1:0]  att_r_o,
  output logic              err_o
);
  mode_cfg_t prog_cfg;

  assign prog_cfg = mode_cfg_t'(mode_q_i);

  always_comb begin
    cfg_o   = prog_i ? prog_cfg : mode_cfg_t'(MODE_STANDALONE);
    att_l_o = prog_i ? att_l_i : '0;
    att_r_o = prog_i ? att_r_i : '0;
    err_o   = prog_i && (prog_cfg.rsv_a || prog_cfg.rsv_b ||
                         (prog_cfg.os == OS_NONE) ||
                         ((prog_cfg.os == OS_2X) && (prog_cfg.wsz != WSZ_24)));
  end
endmodule

// File: rtl/mode_ctl_port.sv
module mode_ctl_port
  import mcp_pkg::*;
#(
  parameter int ATT_W       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_en,
  input  logic [2:0]       cmd_sel,
  input  logic             ser_bit,
  input  logic             strobe,
  output logic [1:0]       os_code,
  output logic [1:0]       word_size,
  output logic             in_fall_latch,
  output logic             in_rjust,
  output logic             wck_rise,
  output logic             out_offset_bin,
  output logic             lr_fall_start,
  output logic [4:0]       dg_fall_slot,
  output logic [4:0]       dg_rise_slot,
  output logic [2:0]       dither_mode,
  output logic [ATT_W-1:0] att_left,
  output logic [ATT_W-1:0] att_right,
  output logic             cfg_err
);
  logic              edge_pulse;
  logic              mode_we, att_we_l, att_we_r, att_zero;
  logic [MODE_W-1:0] mode_word, mode_q;
  logic [ATT_W-1:0]  att_word, att_l_q, att_r_q;
  mode_cfg_t         cfg;

  mcp_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .rise_o(edge_pulse)
  );

  mcp_shifter #(.ATT_W(ATT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .prog_i(prog_en), .rise_i(edge_pulse),
    .cmd_i(cmd_sel), .bit_i(ser_bit),
    .mode_we_o(mode_we), .mode_word_o(mode_word),
    .att_we_l_o(att_we_l), .att_we_r_o(att_we_r),
    .att_zero_o(att_zero), .att_word_o(att_word)
  );

  mcp_cfg_regs #(.ATT_W(ATT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .mode_we_i(mode_we), .mode_word_i(mode_word),
    .att_we_l_i(att_we_l), .att_we_r_i(att_we_r),
    .att_zero_i(att_zero), .att_word_i(att_word),
    .mode_q_o(mode_q), .att_l_o(att_l_q), .att_r_o(att_r_q)
  );

  mcp_cfg_view #(.ATT_W(ATT_W)) u_view (
    .prog_i(prog_en), .mode_q_i(mode_q),
    .att_l_i(att_l_q), .att_r_i(att_r_q),
    .cfg_o(cfg), .att_l_o(att_left), .att_r_o(att_right), .err_o(cfg_err)
  );

  logic unused_rsv;
  assign unused_rsv = cfg.rsv_a ^ cfg.rsv_b;

  assign os_code        = cfg.os;
  assign word_size      = cfg.wsz;
  assign in_fall_latch  = cfg.fall_lat;
  assign in_rjust       = cfg.rjust;
  assign wck_rise       = cfg.wck_rise;
  assign out_offset_bin = cfg.offs_bin;
  assign lr_fall_start  = cfg.lr_fall;
  assign dg_fall_slot   = cfg.dg_fall;
  assign dg_rise_slot   = cfg.dg_rise;
  assign dither_mode    = cfg.dither;
endmodule

// File: rtl/mcp_checker.sv
module mcp_checker #(
  parameter int ATT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prog_en,
  input logic             rise,
  input logic [1:0]       os_code,
  input logic [1:0]       word_size,
  input logic [4:0]       dg_fall_slot,
  input logic [ATT_W-1:0] att_left,
  input logic             cfg_err
);
  a_r2_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

  a_r8_standalone: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |-> (os_code == 2'b11 && dg_fall_slot == 5'd15 &&
                  att_left == '0 && !cfg_err));

  a_r9_unused_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && os_code == 2'b00) |-> cfg_err);

  a_r9_narrow_2x: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && os_code == 2'b01 && word_size != 2'b11) |-> cfg_err);

  a_r3_mode_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && $past(prog_en) && $past(prog_en, 2) && !$stable(dg_fall_slot))
      |-> $past(rise, 2));

  a_r4_att_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && $past(prog_en) && $past(prog_en, 2) && !$stable(att_left))
      |-> $past(rise, 2));
endmodule

bind mode_ctl_port mcp_checker #(.ATT_W(ATT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .rise(edge_pulse),
  .os_code(os_code), .word_size(word_size), .dg_fall_slot(dg_fall_slot),
  .att_left(att_left), .cfg_err(cfg_err)
);

// File: tb/tb_mode_ctl_port.sv
module tb_mode_ctl_port;
  localparam int ATT_W = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_en = 1'b1;
  logic [2:0] cmd_sel = 3'b111;
  logic ser_bit = 1'b0;
  logic strobe = 1'b0;
  logic [1:0] os_code, word_size;
  logic in_fall_latch, in_rjust, wck_rise, out_offset_bin, lr_fall_start;
  logic [4:0] dg_fall_slot, dg_rise_slot;
  logic [2:0] dither_mode;
  logic [ATT_W-1:0] att_left, att_right;
  logic cfg_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  mode_ctl_port #(.ATT_W(ATT_W)) dut (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .cmd_sel(cmd_sel),
    .ser_bit(ser_bit), .strobe(strobe),
    .os_code(os_code), .word_size(word_size), .in_fall_latch(in_fall_latch),
    .in_rjust(in_rjust), .wck_rise(wck_rise), .out_offset_bin(out_offset_bin),
    .lr_fall_start(lr_fall_start), .dg_fall_slot(dg_fall_slot),
    .dg_rise_slot(dg_rise_slot), .dither_mode(dither_mode),
    .att_left(att_left), .att_right(att_right), .cfg_err(cfg_err)
  );

  // {expected cfg_err, mode word}
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 24'h2EFBC3},  // 8x, 24b, slots 15/31, dither 5
    {1'b0, 24'h0600C5},  // 2x, 24b, fall-latch, slot 3
    {1'b1, 24'h000001},  // 2x with 16b
    {1'b1, 24'h060000},  // unused rate 00
    {1'b1, 24'h460003},  // reserved A set
    {1'b1, 24'h860003},  // reserved B set
    {1'b0, 24'h3B557E},  // 4x, 18b, all flags, slots 21/10, dither 7
    {1'b1, 24'h040001}   // 2x with 20b
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic [2:0] cmd, input logic b, input int hold = 4);
    @(negedge clk);
    cmd_sel = cmd;
    ser_bit = b;
    repeat (2) @(negedge clk);
    strobe = 1'b1;
    repeat (hold) @(negedge clk);
    strobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_mode(input logic [23:0] w);
    for (int i = 0; i < 24; i++) send_bit(3'b000, w[i]);
    repeat (4) @(negedge clk);
  endtask

  task automatic send_att(input logic [2:0] cmd, input logic [ATT_W-1:0] v);
    for (int i = ATT_W - 1; i >= 0; i--) send_bit(cmd, v[i]);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_fields(input string req, input logic [23:0] w);
    check(req, "os_code",   32'(os_code),        32'({w[1], w[0]}));
    check(req, "word_size", 32'(word_size),      32'({w[18], w[17]}));
    check(req, "fall_lat",  32'(in_fall_latch),  32'(w[2]));
    check(req, "rjust",     32'(in_rjust),       32'(w[3]));
    check(req, "wck_rise",  32'(wck_rise),       32'(w[4]));
    check(req, "offs_bin",  32'(out_offset_bin), 32'(w[5]));
    check(req, "dg_fall",   32'(dg_fall_slot),   32'(w[10:6]));
    check(req, "dg_rise",   32'(dg_rise_slot),   32'(w[15:11]));
    check(req, "lr_fall",   32'(lr_fall_start),  32'(w[16]));
    check(req, "dither",    32'(dither_mode),    32'(w[21:19]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_fields("R1", 24'h06FBC3);
    check("R1", "att_left",  32'(att_left),  32'h0);
    check("R1", "att_right", 32'(att_right), 32'h0);
    check("R1", "cfg_err",   32'(cfg_err),   32'h0);

    // R3 R9 R10 table walk
    for (int i = 0; i < 8; i++) begin
      send_mode(VEC[i][23:0]);
      check_fields("R3_R10", VEC[i][23:0]);
      check("R9", "cfg_err", 32'(cfg_err), 32'(VEC[i][24]));
    end

    // R3 no commit before 24th bit
    send_mode(24'h06FBC3);
    for (int i = 0; i < 23; i++) send_bit(3'b000, 1'b0);
    repeat (4) @(negedge clk);
    check("R3", "fall slot before 24th bit", 32'(dg_fall_slot), 32'd15);
    send_bit(3'b000, 1'b0);
    repeat (4) @(negedge clk);
    check("R3", "os after 24th bit", 32'(os_code), 32'd0);
    check("R9", "err after zero word", 32'(cfg_err), 32'd1);

    // R4 left, right, both
    send_att(3'b001, 9'h1A5);
    check("R4", "left load",       32'(att_left),  32'h1A5);
    check("R4", "right untouched", 32'(att_right), 32'h0);
    send_att(3'b010, 9'h0F0);
    check("R4", "right load",     32'(att_right), 32'h0F0);
    check("R4", "left untouched", 32'(att_left),  32'h1A5);
    send_att(3'b011, 9'h13C);
    check("R4", "both left",  32'(att_left),  32'h13C);
    check("R4", "both right", 32'(att_right), 32'h13C);

    // R6 no-op codes
    for (int c = 5; c < 8; c++)
      for (int k = 0; k < 9; k++) send_bit(3'(c), 1'b1);
    repeat (4) @(negedge clk);
    check("R6", "left after no-ops",  32'(att_left),     32'h13C);
    check("R6", "right after no-ops", 32'(att_right),    32'h13C);
    check("R6", "mode after no-ops",  32'(dg_fall_slot), 32'd0);

    // R5 zero, landing on a half-shifted load; R7 restart afterwards
    for (int k = 0; k < 4; k++) send_bit(3'b001, 1'b1);
    send_bit(3'b100, 1'b0);
    repeat (4) @(negedge clk);
    check("R5", "zero left",  32'(att_left),  32'h0);
    check("R5", "zero right", 32'(att_right), 32'h0);
    send_att(3'b001, 9'h055);
    check("R7", "clean load after zero", 32'(att_left), 32'h055);

    // R7 partial mode word discarded on command change
    send_mode(24'h2EFBC3);
    for (int k = 0; k < 10; k++) send_bit(3'b000, 1'b0);
    send_att(3'b010, 9'h1FF);
    check("R7", "right after switch", 32'(att_right), 32'h1FF);
    check("R7", "mode kept", 32'(dither_mode), 32'd5);
    send_mode(24'h3B557E);
    check_fields("R7", 24'h3B557E);

    // R2 long strobe takes one bit
    for (int i = ATT_W - 1; i >= 0; i--)
      send_bit(3'b001, i[0], (i == 4) ? 25 : 4);
    repeat (4) @(negedge clk);
    check("R2", "long strobe single bit", 32'(att_left), 32'h0AA);

    // R8 stand-alone defaults and ignored strobes
    @(negedge clk);
    prog_en = 1'b0;
    @(negedge clk);
    check_fields("R8", 24'h06FBC3);
    check("R8", "att_left",  32'(att_left), 32'h0);
    check("R8", "cfg_err",   32'(cfg_err),  32'h0);
    for (int k = 0; k < 5; k++) send_bit(3'b100, 1'b0);
    send_att(3'b011, 9'h001);
    @(negedge clk);
    prog_en = 1'b1;
    @(negedge clk);
    check("R8", "left kept",  32'(att_left),  32'h0AA);
    check("R8", "right kept", 32'(att_right), 32'h1FF);
    check_fields("R8", 24'h3B557E);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule